// File: doc/BRIEF.md
# Cipher Round-Key Expansion Engine

This block turns a user key of 16, 24 or 32 bytes into the 44-word table of 32-bit round keys used by a 20-round block cipher built on data-dependent rotations. A one-cycle start pulse captures the key and the length select. The engine then works in two phases. The fill phase writes one table word per clock from an arithmetic progression. The mix phase runs 132 mixing steps, one per clock, that fold the key words into the table.

The mix phase keeps two running accumulators. It walks the table and the key-word array with two separate wrap counters: the table counter wraps at 44, the key counter at the number of key words. Each step rotates the table word left by three. It rotates the key word by an amount taken from the sum of both accumulators, computed within that same step. When the last step finishes, a done pulse is raised. The finished table can then be read through a combinational port indexed by key number, and it stays unchanged until the next start.

Top module: `rkx_engine`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and every table index reads 0 on `rd_data`.
- R2: A `start` sampled high while idle raises `busy` at the next clock edge. `busy` then stays high for exactly 176 cycles: 44 fill cycles followed by 132 mix cycles.
- R3: `done` is high for exactly one cycle. It rises on the same edge at which `busy` falls, and it is never high together with `busy`.
- R4: When the run ends, table word k holds the result of the following procedure. Start with the words 0xB7E15163 + k·0x9E3779B9 (mod 2^32), and set the accumulators a, b and the counters i, j to zero. Then repeat 132 times: a = rotl(S[i]+a+b, 3) and S[i] = a; b = rotl(L[j]+a+b, (a+b) mod 32) and L[j] = b; i = (i+1) mod 44; j = (j+1) mod c.
- R5: `key_bytes` holds key byte n in bits [8n+7:8n]. Key word L[w] is made from bytes 4w to 4w+3, little-endian, so byte 4w sits in bits 7:0 of that word.
- R6: `key_len` selects c: code 0 gives 4 words (16 bytes), code 1 gives 6 words (24 bytes), and codes 2 and 3 give 8 words (32 bytes). Key bytes above the selected length have no effect on the table.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The run keeps its length and its result.
- R8: `rd_data` shows table word `rd_idx` in the same cycle. Any index from 44 to 63 reads 0.
- R9: While the engine is idle, the table does not change, so a repeated read of an index returns the same word.
- R10: `key_bytes` and `key_len` are sampled only when a start is accepted. Changing them during a run does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to expand the presented key |
| key_len | input | 2 | Key length code (0: 16 B, 1: 24 B, 2/3: 32 B) |
| key_bytes | input | 256 | Key bytes, byte n at bits [8n+7:8n] |
| busy | output | 1 | High while filling or mixing |
| done | output | 1 | One-cycle pulse when the table is complete |
| rd_idx | input | 6 | Round-key index to read |
| rd_data | output | 32 | Round-key word at `rd_idx`, 0 when the index is 44 or above |

## Verification
The assertions assume that `rd_idx` only changes while the engine is idle. Under that assumption, a read that moves between cycles, or a write, is the only thing that can alter `rd_data`. They also take it as given that `start` may arrive at any time, including during a run. The stimulus moves `rd_idx` only after `done`, and it deliberately pulses `start` and changes the key inputs in the middle of a run. A behavioural model in the bench tracks the expected `busy` and `done` on every clock and checks them there. After each run it compares the whole table, and the out-of-range indices, against an expansion computed in the bench.

// File: rtl/rkx_pkg.sv
`timescale 1ns/1ps
package rkx_pkg;

    localparam int WORD_W        = 32;
    localparam int KEY_WORDS_MAX = 8;
    localparam int KEY_BITS      = KEY_WORDS_MAX * WORD_W;
    localparam int TBL_LEN       = 44;
    localparam int MIX_ITERS     = 3 * TBL_LEN;
    localparam int IDX_W         = 6;
    localparam int KW_W          = $clog2(KEY_WORDS_MAX);
    localparam int STEP_W        = $clog2(MIX_ITERS);
    localparam int ROT_W         = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t SEED_WORD = 32'hB7E15163;
    localparam word_t STEP_WORD = 32'h9E3779B9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_MIX  = 2'd2
    } phase_e;

    typedef struct packed {
        word_t acc_a;
        word_t acc_b;
    } acc_t;

    typedef struct packed {
        word_t s_new;
        word_t l_new;
    } mix_out_t;

    function automatic word_t rotl(input word_t v, input logic [ROT_W-1:0] n);
        logic [2*WORD_W-1:0] t;
        t = {v, v} << n;
        return t[2*WORD_W-1:WORD_W];
    endfunction

    function automatic logic [KW_W-1:0] last_word(input logic [1:0] sel);
        case (sel)
            2'd0:    return KW_W'(3);
            2'd1:    return KW_W'(5);
            default: return KW_W'(KEY_WORDS_MAX - 1);
        endcase
    endfunction

endpackage

// File: rtl/rkx_ctrl.sv
`timescale 1ns/1ps
module rkx_ctrl
    import rkx_pkg::*;
#(
    parameter int TABLE_LEN = TBL_LEN,
    parameter int STEPS     = MIX_ITERS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      key_len,
    output logic            busy,
    output logic            done,
    output logic            load_key,
    output logic            fill_en,
    output logic            mix_en,
    output logic [IDX_W-1:0] s_idx,
    output logic [KW_W-1:0]  l_idx
);

    localparam logic [IDX_W-1:0]  S_LAST    = IDX_W'(TABLE_LEN - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    phase_e             phase_q;
    logic [STEP_W-1:0]  step_q;
    logic [KW_W-1:0]    l_last_q;
    logic               last_step;

    assign busy      = (phase_q != PH_IDLE);
    assign load_key  = (phase_q == PH_IDLE) && start;
    assign fill_en   = (phase_q == PH_FILL);
    assign mix_en    = (phase_q == PH_MIX);
    assign last_step = mix_en && (step_q == STEP_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            s_idx    <= '0;
            l_idx    <= '0;
            step_q   <= '0;
            l_last_q <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_FILL;
                        s_idx    <= '0;
                        l_last_q <= last_word(key_len);
                    end
                end
                PH_FILL: begin
                    if (s_idx == S_LAST) begin
                        s_idx   <= '0;
                        l_idx   <= '0;
                        step_q  <= '0;
                        phase_q <= PH_MIX;
                    end else begin
                        s_idx <= s_idx + 1'b1;
                    end
                end
                PH_MIX: begin
                    s_idx <= (s_idx == S_LAST)   ? '0 : s_idx + 1'b1;
                    l_idx <= (l_idx == l_last_q) ? '0 : l_idx + 1'b1;
                    if (last_step) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r2_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !last_step) |=> busy);
    a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
        mix_en |-> (s_idx <= S_LAST && l_idx <= l_last_q));

endmodule

// File: rtl/rkx_keyreg.sv
`timescale 1ns/1ps
module rkx_keyreg
    import rkx_pkg::*;
#(
    parameter int WORDS = KEY_WORDS_MAX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [WORDS*WORD_W-1:0] key_in,
    input  logic                    we,
    input  logic [KW_W-1:0]         idx,
    input  word_t                   wdata,
    output word_t                   rdata
);

    word_t kw_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                kw_q[w] <= '0;
            end else if (load) begin
                kw_q[w] <= key_in[w*WORD_W +: WORD_W];
            end else if (we && (idx == KW_W'(w))) begin
                kw_q[w] <= wdata;
            end
        end
    end

    assign rdata = kw_q[idx];

endmodule

// File: rtl/rkx_table.sv
`timescale 1ns/1ps
module rkx_table
    import rkx_pkg::*;
#(
    parameter int TABLE_LEN = TBL_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             fill_en,
    input  logic             mix_we,
    input  logic [IDX_W-1:0] w_idx,
    input  word_t            wdata,
    output word_t            mix_rdata,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data
);

    word_t mem_q [TABLE_LEN];
    word_t run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (load) begin
            run_q <= SEED_WORD;
        end else if (fill_en) begin
            run_q <= run_q + STEP_WORD;
        end
    end

    for (genvar k = 0; k < TABLE_LEN; k++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[k] <= '0;
            end else if (w_idx == IDX_W'(k)) begin
                if (fill_en) begin
                    mem_q[k] <= run_q;
                end else if (mix_we) begin
                    mem_q[k] <= wdata;
                end
            end
        end
    end

    always_comb begin
        mix_rdata = '0;
        rd_data   = '0;
        for (int k = 0; k < TABLE_LEN; k++) begin
            if (w_idx == IDX_W'(k))  mix_rdata = mem_q[k];
            if (rd_idx == IDX_W'(k)) rd_data   = mem_q[k];
        end
    end

    a_r9_table_hold: assert property (@(posedge clk) disable iff (rst)
        (!fill_en && !mix_we) |=> ((rd_idx != $past(rd_idx)) || $stable(rd_data)));

endmodule

// File: rtl/rkx_mix.sv
`timescale 1ns/1ps
module rkx_mix
    import rkx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     en,
    input  word_t    s_rd,
    input  word_t    l_rd,
    output mix_out_t res
);

    acc_t  acc_q;
    word_t ab_sum;

    always_comb begin
        res.s_new = rotl(s_rd + acc_q.acc_a + acc_q.acc_b, ROT_W'(3));
        ab_sum    = res.s_new + acc_q.acc_b;
        res.l_new = rotl(l_rd + ab_sum, ab_sum[ROT_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q.acc_a <= res.s_new;
            acc_q.acc_b <= res.l_new;
        end
    end

endmodule

// File: rtl/rkx_engine.sv
`timescale 1ns/1ps
module rkx_engine
    import rkx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          key_len,
    input  logic [KEY_BITS-1:0] key_bytes,
    output logic                busy,
    output logic                done,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [WORD_W-1:0]   rd_data
);

    logic             load_key;
    logic             fill_en;
    logic             mix_en;
    logic [IDX_W-1:0] s_idx;
    logic [KW_W-1:0]  l_idx;
    word_t            s_rd;
    word_t            l_rd;
    mix_out_t         mix_res;

    rkx_ctrl #(.TABLE_LEN(TBL_LEN), .STEPS(MIX_ITERS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key_len  (key_len),
        .busy     (busy),
        .done     (done),
        .load_key (load_key),
        .fill_en  (fill_en),
        .mix_en   (mix_en),
        .s_idx    (s_idx),
        .l_idx    (l_idx)
    );

    rkx_keyreg #(.WORDS(KEY_WORDS_MAX)) u_keys (
        .clk    (clk),
        .rst    (rst),
        .load   (load_key),
        .key_in (key_bytes),
        .we     (mix_en),
        .idx    (l_idx),
        .wdata  (mix_res.l_new),
        .rdata  (l_rd)
    );

    rkx_table #(.TABLE_LEN(TBL_LEN)) u_table (
        .clk       (clk),
        .rst       (rst),
        .load      (load_key),
        .fill_en   (fill_en),
        .mix_we    (mix_en),
        .w_idx     (s_idx),
        .wdata     (mix_res.s_new),
        .mix_rdata (s_rd),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    rkx_mix u_mix (
        .clk  (clk),
        .rst  (rst),
        .clr  (load_key),
        .en   (mix_en),
        .s_rd (s_rd),
        .l_rd (l_rd),
        .res  (mix_res)
    );

    a_r8_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (rd_idx >= IDX_W'(TBL_LEN)) |-> (rd_data == '0));

endmodule

// File: tb/rkx_engine_tb_top.sv
`timescale 1ns/1ps
module rkx_engine_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   key_len = 2'd0;
    logic [255:0] key_bytes = '0;
    logic         busy;
    logic         done;
    logic [5:0]   rd_idx = '0;
    logic [31:0]  rd_data;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    bit exp_busy = 0;
    bit exp_done = 0;
    int remain = 0;
    logic [31:0] ref_tab [44];

    always #2.5 clk = ~clk;

    rkx_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .key_len(key_len),
        .key_bytes(key_bytes), .busy(busy), .done(done),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rol(input logic [31:0] x, input int n);
        int m;
        m = n % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    function automatic void build_ref(input logic [255:0] key, input int nw);
        logic [31:0] lw [8];
        logic [31:0] a, b;
        int i, j;
        for (int k = 0; k < 44; k++) ref_tab[k] = 32'hB7E15163 + 32'(k) * 32'h9E3779B9;
        for (int w = 0; w < 8; w++)
            for (int y = 0; y < 4; y++) lw[w][8*y +: 8] = key[8*(4*w+y) +: 8];
        a = 0; b = 0; i = 0; j = 0;
        for (int n = 0; n < 132; n++) begin
            a = rol(ref_tab[i] + a + b, 3);
            ref_tab[i] = a;
            b = rol(lw[j] + a + b, int'((a + b) & 32'h1F));
            lw[j] = b;
            i = (i + 1) % 44;
            j = (j + 1) % nw;
        end
    endfunction

    // One clock: model busy/done per cycle and compare (R2, R3)
    task automatic step();
        bit st;
        st = start && !exp_busy;
        @(posedge clk);
        #1;
        exp_done = 0;
        if (exp_busy) begin
            remain--;
            if (remain == 0) begin
                exp_busy = 0;
                exp_done = 1;
            end
        end else if (st) begin
            exp_busy = 1;
            remain = 176;
        end
        check("R2 busy", 32'(busy), 32'(exp_busy));
        check("R3 done", 32'(done), 32'(exp_done));
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 64; k++) begin
            rd_idx = 6'(k);
            #0.2;
            if (k < 44) check(req, rd_data, ref_tab[k]);
            else        check("R8 out-of-range read", rd_data, 32'h0);
        end
        rd_idx = '0;
    endtask

    // Run a full expansion; optionally disturb inputs mid-run (R7, R10)
    task automatic run(input logic [255:0] key, input logic [1:0] sel, input int nw,
                       input bit disturb, input string req);
        key_bytes = key;
        key_len = sel;
        build_ref(key, nw);
        start = 1;
        step();
        start = 0;
        for (int c = 0; c < 176; c++) begin
            if (disturb && (c == 20 || c == 100)) begin
                start = 1;
                key_bytes = ~key;
                key_len = 2'd0;
            end
            step();
            start = 0;
        end
        check("R3 done seen", 32'(done), 32'd1);
        read_all(req);
        step();
        step();
        rd_idx = 6'd7;
        #0.2;
        check("R9 idle hold", rd_data, ref_tab[7]);
        rd_idx = '0;
    endtask

    initial begin
        logic [255:0] pat;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1: reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        rd_idx = 6'd5;
        #0.2;
        check("R1 table", rd_data, 32'h0);
        rd_idx = 6'd43;
        #0.2;
        check("R1 table", rd_data, 32'h0);
        rd_idx = 6'd0;
        step();

        run('0, 2'd0, 4, 0, "R4 zero key 16B");
        for (int n = 0; n < 32; n++) pat[8*n +: 8] = 8'(n * 17 + 3);
        run(pat, 2'd0, 4, 0, "R5 packing 16B");
        pat[255:128] = ~pat[255:128];
        run(pat, 2'd0, 4, 0, "R6 upper bytes ignored 16B");
        run(pat, 2'd1, 6, 0, "R6 24B");
        run(pat, 2'd2, 8, 0, "R6 32B");
        run({8{32'hDEADBEEF}} ^ pat, 2'd3, 8, 0, "R6 code 3 as 32B");
        run(pat, 2'd1, 6, 1, "R7 R10 mid-run start and key change");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule